// File: doc/BRIEF.md
# Per-Register Segment Descriptor Loader

This block loads one of eight segment registers under a protection scheme in which every segment register owns a private local table. A load names a target register and a 16-bit selector. The selector picks which register's local table to consult and an index into it. The local entry found there holds only a global-table index and a valid flag. The unit then fetches the four-word global descriptor that this index names. The descriptor holds a segment base and limit, plus the base and limit of the segment's own local table.

A successful load writes all four words into the target register. The target register therefore changes its local table as a side effect of the load. A segment can only be reached through an entry of a local table that is already installed: no selector encoding reaches the global table directly. Memory is read through a valid/ready request channel with one outstanding 32-bit read at a time. A privileged configuration port sets the global table location and size and preloads any register's local-table location and size. A combinational view port lets the surrounding logic read any register.

Top module: `seg_desc_loader`

## Requirements
- R1: After reset every register field (segment base, segment limit, local-table base, local-table limit) is zero, the global base and limit are zero, `busy` is low and `req_ready` is high; a load issued before any configuration therefore faults with cause 1 and makes no memory read.
- R2: When `cfg_we` is high and the unit is idle, `cfg_data` is written at the next clock edge. `cfg_addr[4]`=0 selects the global table, and `cfg_addr[0]` picks the base (0) or the limit (1). `cfg_addr[4]`=1 selects the local-table base (`cfg_addr[0]`=0) or limit (`cfg_addr[0]`=1) of register `cfg_addr[3:1]`. A write presented while `busy` is high is ignored.
- R3: Selector bits [4:2] name the register whose local table is consulted, whatever the target. Bits [15:5] form the entry index. Bits [1:0] have no effect. The entry is read from local-table base + 4 × index.
- R4: If the entry index is greater than or equal to the consulted local-table limit (a count of entries), the load faults with cause 1 without any memory read, and no register changes.
- R5: A local entry has its valid flag in bit 31 and the global index in bits [15:0]. Bits [30:16] are ignored. An entry with bit 31 clear faults with cause 2 after exactly one read, and no register changes.
- R6: If the global index is greater than or equal to the global limit (a count of descriptors), the load faults with cause 3 after exactly one read, and no register changes.
- R7: Otherwise four words are read from global base + 16 × index + 4 × k, for k = 0..3. These words are the segment base, segment limit, local-table base and local-table limit. All four are written into the target register. `done` pulses for one cycle, and the new values are visible on the view port in that cycle.
- R8: At most one read is outstanding. While `mem_rd_valid` is high and `mem_rd_ready` is low, the request and its address stay unchanged.
- R9: `busy` rises the cycle after a request is accepted and stays high up to and including the `done` or `fault` cycle. While busy, `req_ready` is low and requests are ignored.
- R10: `done` and `fault` are never high together, and each lasts exactly one cycle. `fault_cause` is 0 except during a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Load request present |
| req_ready | output | 1 | Unit idle, request accepted when valid |
| req_reg | input | 3 | Target register of the load |
| req_sel | input | 16 | Selector |
| busy | output | 1 | Load in progress |
| done | output | 1 | One-cycle pulse: load succeeded |
| fault | output | 1 | One-cycle pulse: load refused |
| fault_cause | output | 2 | 1 local limit, 2 invalid entry, 3 global limit |
| mem_rd_valid | output | 1 | Read request |
| mem_rd_ready | input | 1 | Read request accepted |
| mem_rd_addr | output | 32 | Byte address of the read |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Read data |
| cfg_we | input | 1 | Privileged configuration write |
| cfg_addr | input | 5 | Configuration field select |
| cfg_data | input | 32 | Configuration value |
| view_reg | input | 3 | Register shown on the view port |
| view_seg_base | output | 32 | Segment base of the viewed register |
| view_seg_limit | output | 32 | Segment limit of the viewed register |
| view_ldt_base | output | 32 | Local-table base of the viewed register |
| view_ldt_limit | output | 32 | Local-table limit of the viewed register |

## Verification
The hardest case to reach is a chain in which one load changes the local table that a later load consults through a different target register. It also includes the rarer case where the target and the consulted table are the same register. A single directed load does not reach it. The bench sweeps every target, every consulted table and eight entry indices in a nested order. Its memory contents are computed from the address, so the installed tables keep changing and the three fault causes and successful loads stay mixed. The read channel stalls in a repeating pattern with varying response delay, and a request plus a configuration write are forced in while a load is busy.

// File: rtl/segldr_pkg.sv
`timescale 1ns/1ps
package segldr_pkg;
  parameter int WORD_W      = 32;
  parameter int SEL_W       = 16;
  parameter int TBL_BITS    = 3;
  parameter int TBL_LSB     = 2;
  parameter int GIDX_W      = 16;
  parameter int GDESC_WORDS = 4;

  localparam int NREG       = 1 << TBL_BITS;
  localparam int IDX_W      = SEL_W - TBL_LSB - TBL_BITS;
  localparam int CFG_AW     = TBL_BITS + 2;
  localparam int VALID_BIT  = WORD_W - 1;
  localparam int WORD_BYTES = WORD_W / 8;
  localparam int DESC_BYTES = GDESC_WORDS * WORD_BYTES;
  localparam int WCNT_W     = $clog2(GDESC_WORDS);

  typedef struct packed {
    logic [WORD_W-1:0] seg_base;
    logic [WORD_W-1:0] seg_limit;
    logic [WORD_W-1:0] ldt_base;
    logic [WORD_W-1:0] ldt_limit;
  } segreg_t;

  typedef enum logic [1:0] {
    FC_NONE          = 2'd0,
    FC_LDT_LIMIT     = 2'd1,
    FC_ENTRY_INVALID = 2'd2,
    FC_GDT_LIMIT     = 2'd3
  } fcause_t;

  // consulted table: a field a neighbour decodes, so its position is fixed
  function automatic logic [TBL_BITS-1:0] sel_table(input logic [SEL_W-1:0] s);
    return s[TBL_LSB +: TBL_BITS];
  endfunction

  function automatic logic [IDX_W-1:0] sel_index(input logic [SEL_W-1:0] s);
    return s[SEL_W-1 -: IDX_W];
  endfunction

  function automatic logic [WORD_W-1:0] ldt_entry_addr(input logic [WORD_W-1:0] base,
                                                       input logic [IDX_W-1:0]  idx);
    return base + WORD_W'(idx) * WORD_W'(WORD_BYTES);
  endfunction

  function automatic logic [WORD_W-1:0] gdt_word_addr(input logic [WORD_W-1:0] base,
                                                      input logic [GIDX_W-1:0] gidx,
                                                      input logic [WCNT_W-1:0] w);
    return base + WORD_W'(gidx) * WORD_W'(DESC_BYTES) + WORD_W'(w) * WORD_W'(WORD_BYTES);
  endfunction

  function automatic logic below_limit(input logic [WORD_W-1:0] idx,
                                       input logic [WORD_W-1:0] limit);
    return idx < limit;
  endfunction

  function automatic logic entry_valid(input logic [WORD_W-1:0] e);
    return e[VALID_BIT];
  endfunction

  function automatic logic [GIDX_W-1:0] entry_gidx(input logic [WORD_W-1:0] e);
    return e[GIDX_W-1:0];
  endfunction
endpackage

// File: rtl/segldr_regfile.sv
`timescale 1ns/1ps
module segldr_regfile
  import segldr_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_en,
  input  logic [CFG_AW-1:0]   cfg_addr,
  input  logic [WORD_W-1:0]   cfg_data,
  input  logic                commit_en,
  input  logic [TBL_BITS-1:0] commit_idx,
  input  segreg_t             commit_val,
  input  logic [TBL_BITS-1:0] look_idx,
  output logic [WORD_W-1:0]   look_ldt_base,
  output logic [WORD_W-1:0]   look_ldt_limit,
  output logic [WORD_W-1:0]   gdt_base,
  output logic [WORD_W-1:0]   gdt_limit,
  input  logic [TBL_BITS-1:0] view_idx,
  output segreg_t             view_val
);
  segreg_t [NREG-1:0] regs;

  logic cfg_is_reg;
  logic cfg_is_limit;
  logic [TBL_BITS-1:0] cfg_reg;
  assign cfg_is_reg   = cfg_addr[CFG_AW-1];
  assign cfg_is_limit = cfg_addr[0];
  assign cfg_reg      = cfg_addr[TBL_BITS:1];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    segreg_t r_q;
    logic hit_commit, hit_cfg;
    assign hit_commit = commit_en && (commit_idx == TBL_BITS'(g));
    assign hit_cfg    = cfg_en && cfg_is_reg && (cfg_reg == TBL_BITS'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        r_q <= '0;
      end else if (hit_commit) begin
        r_q <= commit_val;
      end else if (hit_cfg) begin
        if (cfg_is_limit) r_q.ldt_limit <= cfg_data;
        else              r_q.ldt_base  <= cfg_data;
      end
    end
    assign regs[g] = r_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gdt_base  <= '0;
      gdt_limit <= '0;
    end else if (cfg_en && !cfg_is_reg) begin
      if (cfg_is_limit) gdt_limit <= cfg_data;
      else              gdt_base  <= cfg_data;
    end
  end

  assign look_ldt_base  = regs[look_idx].ldt_base;
  assign look_ldt_limit = regs[look_idx].ldt_limit;
  assign view_val       = regs[view_idx];
endmodule

// File: rtl/segldr_walker.sv
`timescale 1ns/1ps
module segldr_walker
  import segldr_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [TBL_BITS-1:0] req_reg,
  input  logic [SEL_W-1:0]    req_sel,
  output logic                busy,
  output logic                done,
  output logic                fault,
  output logic [1:0]          fault_cause,
  output logic [TBL_BITS-1:0] look_idx,
  input  logic [WORD_W-1:0]   look_ldt_base,
  input  logic [WORD_W-1:0]   look_ldt_limit,
  input  logic [WORD_W-1:0]   gdt_base,
  input  logic [WORD_W-1:0]   gdt_limit,
  output logic                mem_rd_valid,
  input  logic                mem_rd_ready,
  output logic [WORD_W-1:0]   mem_rd_addr,
  input  logic                mem_rsp_valid,
  input  logic [WORD_W-1:0]   mem_rsp_data,
  output logic                commit_en,
  output logic [TBL_BITS-1:0] commit_idx,
  output segreg_t             commit_val,
  output logic                ev_accept,
  output logic                ev_wait_rsp
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_LCHK, ST_LREQ, ST_LWAIT, ST_GREQ, ST_GWAIT, ST_FIN
  } wstate_t;

  localparam logic [WCNT_W-1:0] LAST_WORD = WCNT_W'(GDESC_WORDS - 1);

  wstate_t                state_q;
  logic [TBL_BITS-1:0]    tgt_q;
  logic [SEL_W-1:0]       sel_q;
  logic [GIDX_W-1:0]      gidx_q;
  logic [WCNT_W-1:0]      wcnt_q;
  logic [GDESC_WORDS-2:0][WORD_W-1:0] words_q;
  logic                   ok_q;
  fcause_t                cause_q;

  logic ev_lim_fail, ev_ent_fail, ev_gdt_fail;
  logic unused_meta;

  assign unused_meta = ^mem_rsp_data[VALID_BIT-1:GIDX_W];

  assign req_ready   = (state_q == ST_IDLE);
  assign busy        = (state_q != ST_IDLE);
  assign ev_accept   = req_ready && req_valid;
  assign ev_wait_rsp = (state_q == ST_LWAIT) || (state_q == ST_GWAIT);
  assign look_idx    = sel_table(sel_q);

  assign ev_lim_fail = (state_q == ST_LCHK) &&
                       !below_limit(WORD_W'(sel_index(sel_q)), look_ldt_limit);
  assign ev_ent_fail = (state_q == ST_LWAIT) && mem_rsp_valid && !entry_valid(mem_rsp_data);
  assign ev_gdt_fail = (state_q == ST_LWAIT) && mem_rsp_valid && entry_valid(mem_rsp_data) &&
                       !below_limit(WORD_W'(entry_gidx(mem_rsp_data)), gdt_limit);

  assign mem_rd_valid = (state_q == ST_LREQ) || (state_q == ST_GREQ);
  always_comb begin
    if (state_q == ST_GREQ) mem_rd_addr = gdt_word_addr(gdt_base, gidx_q, wcnt_q);
    else                    mem_rd_addr = ldt_entry_addr(look_ldt_base, sel_index(sel_q));
  end

  assign commit_en  = (state_q == ST_GWAIT) && mem_rsp_valid && (wcnt_q == LAST_WORD);
  assign commit_idx = tgt_q;
  assign commit_val = '{seg_base:  words_q[0],
                        seg_limit: words_q[1],
                        ldt_base:  words_q[2],
                        ldt_limit: mem_rsp_data};

  assign done        = (state_q == ST_FIN) && ok_q;
  assign fault       = (state_q == ST_FIN) && !ok_q;
  assign fault_cause = (state_q == ST_FIN) ? cause_q : FC_NONE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tgt_q   <= '0;
      sel_q   <= '0;
      gidx_q  <= '0;
      wcnt_q  <= '0;
      words_q <= '0;
      ok_q    <= 1'b0;
      cause_q <= FC_NONE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (ev_accept) begin
          tgt_q   <= req_reg;
          sel_q   <= req_sel;
          state_q <= ST_LCHK;
        end
        ST_LCHK: begin
          if (ev_lim_fail) begin
            ok_q    <= 1'b0;
            cause_q <= FC_LDT_LIMIT;
            state_q <= ST_FIN;
          end else begin
            state_q <= ST_LREQ;
          end
        end
        ST_LREQ: if (mem_rd_ready) state_q <= ST_LWAIT;
        ST_LWAIT: if (mem_rsp_valid) begin
          if (ev_ent_fail) begin
            ok_q    <= 1'b0;
            cause_q <= FC_ENTRY_INVALID;
            state_q <= ST_FIN;
          end else if (ev_gdt_fail) begin
            ok_q    <= 1'b0;
            cause_q <= FC_GDT_LIMIT;
            state_q <= ST_FIN;
          end else begin
            gidx_q  <= entry_gidx(mem_rsp_data);
            wcnt_q  <= '0;
            state_q <= ST_GREQ;
          end
        end
        ST_GREQ: if (mem_rd_ready) state_q <= ST_GWAIT;
        ST_GWAIT: if (mem_rsp_valid) begin
          if (wcnt_q == LAST_WORD) begin
            ok_q    <= 1'b1;
            cause_q <= FC_NONE;
            state_q <= ST_FIN;
          end else begin
            words_q[wcnt_q] <= mem_rsp_data;
            wcnt_q          <= wcnt_q + 1'b1;
            state_q         <= ST_GREQ;
          end
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/seg_desc_loader.sv
`timescale 1ns/1ps
module seg_desc_loader
  import segldr_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [TBL_BITS-1:0] req_reg,
  input  logic [SEL_W-1:0]    req_sel,
  output logic                busy,
  output logic                done,
  output logic                fault,
  output logic [1:0]          fault_cause,
  output logic                mem_rd_valid,
  input  logic                mem_rd_ready,
  output logic [WORD_W-1:0]   mem_rd_addr,
  input  logic                mem_rsp_valid,
  input  logic [WORD_W-1:0]   mem_rsp_data,
  input  logic                cfg_we,
  input  logic [CFG_AW-1:0]   cfg_addr,
  input  logic [WORD_W-1:0]   cfg_data,
  input  logic [TBL_BITS-1:0] view_reg,
  output logic [WORD_W-1:0]   view_seg_base,
  output logic [WORD_W-1:0]   view_seg_limit,
  output logic [WORD_W-1:0]   view_ldt_base,
  output logic [WORD_W-1:0]   view_ldt_limit
);
  logic                cfg_en;
  logic                commit_en;
  logic [TBL_BITS-1:0] commit_idx;
  segreg_t             commit_val;
  logic [TBL_BITS-1:0] look_idx;
  logic [WORD_W-1:0]   look_ldt_base, look_ldt_limit;
  logic [WORD_W-1:0]   gdt_base, gdt_limit;
  segreg_t             view_val;
  logic                ev_accept, ev_wait_rsp;

  // privileged writes only land while no walk can be reading the tables
  assign cfg_en = cfg_we && !busy;

  segldr_regfile u_regs (
    .clk, .rst_n,
    .cfg_en, .cfg_addr, .cfg_data,
    .commit_en, .commit_idx, .commit_val,
    .look_idx, .look_ldt_base, .look_ldt_limit,
    .gdt_base, .gdt_limit,
    .view_idx(view_reg), .view_val
  );

  segldr_walker u_walk (
    .clk, .rst_n,
    .req_valid, .req_ready, .req_reg, .req_sel,
    .busy, .done, .fault, .fault_cause,
    .look_idx, .look_ldt_base, .look_ldt_limit,
    .gdt_base, .gdt_limit,
    .mem_rd_valid, .mem_rd_ready, .mem_rd_addr,
    .mem_rsp_valid, .mem_rsp_data,
    .commit_en, .commit_idx, .commit_val,
    .ev_accept, .ev_wait_rsp
  );

  assign view_seg_base  = view_val.seg_base;
  assign view_seg_limit = view_val.seg_limit;
  assign view_ldt_base  = view_val.ldt_base;
  assign view_ldt_limit = view_val.ldt_limit;
endmodule

// File: rtl/seg_desc_loader_chk.sv
`timescale 1ns/1ps
module seg_desc_loader_chk
  import segldr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              busy,
  input logic              done,
  input logic              fault,
  input logic [1:0]        fault_cause,
  input logic              mem_rd_valid,
  input logic              mem_rd_ready,
  input logic [WORD_W-1:0] mem_rd_addr,
  input logic              commit_en,
  input logic              ev_accept
);
  a_r9_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  a_r9_accept_then_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);

  a_r9_accept_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |-> !busy);

  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault));

  a_r10_fault_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !fault);

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_cause_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !fault |-> (fault_cause == 2'd0));

  a_r8_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

  a_r7_done_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(commit_en));

  a_r4_fault_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !$past(commit_en));
endmodule

bind seg_desc_loader seg_desc_loader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .busy(busy), .done(done), .fault(fault), .fault_cause(fault_cause),
  .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
  .commit_en(commit_en), .ev_accept(ev_accept)
);

// File: tb/seg_desc_loader_test.sv
`timescale 1ns/1ps
module seg_desc_loader_test;
  localparam logic [31:0] GDT_B   = 32'h1000_0000;
  localparam int          GDT_LIM = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_reg = '0;
  logic [15:0] req_sel = '0;
  logic        busy, done, fault;
  logic [1:0]  fault_cause;
  logic        mem_rd_valid;
  logic        mem_rd_ready = 1'b0;
  logic [31:0] mem_rd_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [31:0] cfg_data = '0;
  logic [2:0]  view_reg = '0;
  logic [31:0] view_seg_base, view_seg_limit, view_ldt_base, view_ldt_limit;

  seg_desc_loader uut (.*);

  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  logic [31:0] e_sb [8];
  logic [31:0] e_sl [8];
  logic [31:0] e_lb [8];
  logic [31:0] e_ll [8];

  // memory contents as a function of the address
  function automatic logic [31:0] mem_word(input logic [31:0] a);
    int unsigned t, i, g;
    if (a[31:28] == 4'h2) begin
      t = 32'(a[19:12]);
      i = 32'(a[11:2]);
      return {1'((i % 5) != 4), 15'((t * 7 + i) & 32'h7fff), 16'((t * 3 + i) % 40)};
    end else if (a[31:28] == 4'h1) begin
      g = (a - GDT_B) >> 4;
      case (a[3:2])
        2'd0: return 32'hA000_0000 | (g << 8);
        2'd1: return 32'h0000_0100 + g;
        2'd2: return 32'h2000_0000 + ((g + 1) << 12);
        default: return (g % 6) + 1;
      endcase
    end
    return 32'hDEAD_BEEF;
  endfunction

  // memory responder, driven away from the active edge
  int          reads_cnt = 0;
  logic [31:0] first_addr = '0;
  logic        pend = 1'b0;
  int          pend_cnt = 0;
  logic [31:0] pend_addr = '0;
  int          mcyc = 0;

  always @(negedge clk) begin
    mcyc++;
    mem_rsp_valid = 1'b0;
    if (pend) begin
      if (pend_cnt <= 1) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mem_word(pend_addr);
        pend = 1'b0;
      end else pend_cnt--;
    end
    mem_rd_ready = (mcyc % 3) != 1;
    if (mem_rd_valid && mem_rd_ready) begin
      if (reads_cnt == 0) first_addr = mem_rd_addr;
      reads_cnt++;
      pend      = 1'b1;
      pend_cnt  = 1 + (mcyc % 2);
      pend_addr = mem_rd_addr;
    end
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      report();
    end
  end

  task automatic check_regs(input string req);
    for (int r = 0; r < 8; r++) begin
      view_reg = 3'(r);
      #0.1;
      check(req, $sformatf("reg%0d seg_base", r),  view_seg_base,  e_sb[r]);
      check(req, $sformatf("reg%0d seg_limit", r), view_seg_limit, e_sl[r]);
      check(req, $sformatf("reg%0d ldt_base", r),  view_ldt_base,  e_lb[r]);
      check(req, $sformatf("reg%0d ldt_limit", r), view_ldt_limit, e_ll[r]);
    end
  endtask

  task automatic cfg_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // prediction of one load from the requirements; updates the shadow
  task automatic predict(input int tgt, input logic [15:0] sel,
                         output int cause, output int nreads, output logic [31:0] faddr);
    int t, i;
    logic [31:0] e, g;
    t = int'(sel[4:2]);
    i = int'(sel[15:5]);
    faddr = e_lb[t] + 32'(i) * 4;
    if (32'(i) >= e_ll[t]) begin
      cause = 1; nreads = 0;
    end else begin
      e = mem_word(faddr);
      if (!e[31]) begin
        cause = 2; nreads = 1;
      end else begin
        g = 32'(e[15:0]);
        if (g >= GDT_LIM) begin
          cause = 3; nreads = 1;
        end else begin
          cause = 0; nreads = 5;
          e_sb[tgt] = mem_word(GDT_B + g * 16);
          e_sl[tgt] = mem_word(GDT_B + g * 16 + 4);
          e_lb[tgt] = mem_word(GDT_B + g * 16 + 8);
          e_ll[tgt] = mem_word(GDT_B + g * 16 + 12);
        end
      end
    end
  endtask

  task automatic wait_end(output logic d, output logic f, output logic [1:0] c);
    int k = 0;
    while (!(done || fault) && k < 200) begin
      @(negedge clk);
      k++;
    end
    d = done; f = fault; c = fault_cause;
  endtask

  task automatic run_load(input int tgt, input logic [15:0] sel);
    int cause, nreads;
    logic [31:0] faddr;
    logic d, f;
    logic [1:0] c;
    predict(tgt, sel, cause, nreads, faddr);
    @(negedge clk);
    check("R9", "ready while idle", 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_reg = 3'(tgt); req_sel = sel;
    reads_cnt = 0;
    @(negedge clk);
    req_valid = 1'b0;
    check("R9", "busy after accept", 32'(busy), 32'd1);
    wait_end(d, f, c);
    check("R9", "busy in final cycle", 32'(busy), 32'd1);
    check("R10", "done", 32'(d), 32'(cause == 0));
    check("R10", "fault", 32'(f), 32'(cause != 0));
    if (cause == 1) check("R4", "cause local limit", 32'(c), 32'd1);
    if (cause == 2) check("R5", "cause invalid entry", 32'(c), 32'd2);
    if (cause == 3) check("R6", "cause global limit", 32'(c), 32'd3);
    if (cause == 0) check("R7", "cause none", 32'(c), 32'd0);
    check(cause == 0 ? "R7" : "R4", "read count", 32'(reads_cnt), 32'(nreads));
    if (nreads > 0) check("R3", "entry address", first_addr, faddr);
    check_regs(cause == 0 ? "R7" : "R6");
    @(negedge clk);
    check("R10", "pulse ends", 32'(done | fault), 32'd0);
  endtask

  initial begin
    for (int r = 0; r < 8; r++) begin
      e_sb[r] = '0; e_sl[r] = '0; e_lb[r] = '0; e_ll[r] = '0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "busy after reset", 32'(busy), 32'd0);
    check("R1", "ready after reset", 32'(req_ready), 32'd1);
    check_regs("R1");
    run_load(5, 16'h0024);   // R1: zero limits -> cause 1, no read

    // R2 configuration
    cfg_write(5'b00000, GDT_B);
    cfg_write(5'b00001, 32'(GDT_LIM));
    for (int r = 0; r < 8; r++) begin
      e_lb[r] = 32'h2000_0000 + ((32'(r) + 50) << 12);
      e_ll[r] = 32'd3 + 32'(r % 4);
      cfg_write({1'b1, 3'(r), 1'b0}, e_lb[r]);
      cfg_write({1'b1, 3'(r), 1'b1}, e_ll[r]);
    end
    check_regs("R2");

    // sweep: target x consulted table x index, low bits varied (R3..R7)
    for (int tgt = 0; tgt < 8; tgt++)
      for (int tb = 0; tb < 8; tb++)
        for (int ix = 0; ix < 8; ix++)
          run_load(tgt, {11'(ix), 3'(tb), 2'((tgt + ix) % 4)});

    // R9 / R2: request and configuration write while busy are ignored
    begin
      int cause, nreads;
      logic [31:0] faddr;
      logic d, f;
      logic [1:0] c;
      int tb = 0;
      int ix = 0;
      logic [15:0] s;
      // find a load predicted to succeed without disturbing the shadow
      for (int k = 0; k < 64 && tb == 0; k++) begin
        logic [31:0] en;
        int t2 = k % 8;
        int i2 = k / 8;
        en = mem_word(e_lb[t2] + 32'(i2) * 4);
        if (32'(i2) < e_ll[t2] && en[31] && 32'(en[15:0]) < GDT_LIM) begin
          tb = t2 + 8; ix = i2;
        end
      end
      s = {11'(ix), 3'(tb % 8), 2'b00};
      predict(1, s, cause, nreads, faddr);
      @(negedge clk);
      req_valid = 1'b1; req_reg = 3'd1; req_sel = s;
      reads_cnt = 0;
      @(negedge clk);
      req_sel = 16'hFFE0; req_reg = 3'd6;
      cfg_we = 1'b1; cfg_addr = {1'b1, 3'd7, 1'b1}; cfg_data = 32'h0;
      check("R9", "ready low while busy", 32'(req_ready), 32'd0);
      @(negedge clk);
      req_valid = 1'b0; cfg_we = 1'b0;
      wait_end(d, f, c);
      check("R9", "first load outcome", 32'(d), 32'(cause == 0));
      check("R9", "read count", 32'(reads_cnt), 32'(nreads));
      @(negedge clk);
      check("R9", "no second load", 32'(busy), 32'd0);
      check_regs("R2");
    end
    report();
  end
endmodule